// File: doc/BRIEF.md
# Expansion ROM Version Walker

This block reads the header of an expansion ROM image one byte at a time and extracts the image's version. A pulse on `start` begins a walk. The block first confirms the two-byte boot signature at the start of the image. It then follows a one-byte pointer to the PCI data structure and checks the four-character tag at that location. If every check passes, it returns the minor and major version bytes that sit at fixed offsets inside the structure.

Reads go through a request/valid handshake. The block drives an address and holds `rd_req` high. Any storage behind it answers with `rd_valid` and `rd_data` after any number of wait states. The block keeps exactly one read in flight. It stops at the first byte that does not match, so a bad image costs as few reads as possible. Each walk ends with a one-cycle `done` pulse. A successful walk also raises `ok`.

Top module: `romwalk_top`

## Requirements
- R1: After reset, `done`, `ok` and `rd_req` are low and `ver_major` and `ver_minor` are zero.
- R2: Reads are issued one at a time, in this order: 0x0000, 0x0001, 0x0018, P, P+1, P+2, P+3, P+0x12, P+0x13, where P is the pointer. `rd_req` and `rd_addr` hold steady until `rd_valid` is seen.
- R3: The walk fails unless byte 0x0000 reads 0x55 and byte 0x0001 reads 0xAA.
- R4: The byte read at 0x0018 is zero-extended to `ADDR_W` bits and used as the pointer P.
- R5: The bytes at P..P+3 must be 0x50, 0x43, 0x49 and 0x52 ("PCIR"), or the walk fails.
- R6: On success, `ver_minor` takes the byte at P+0x12, `ver_major` takes the byte at P+0x13, and `ok` is high. All three are valid when `done` is high and are held afterwards.
- R7: After the first mismatching byte the block issues no further read, and `done` follows.
- R8: On failure, `ok` is low and both version outputs are zero. `done` is a single-cycle pulse, given exactly once per walk.
- R9: A `start` pulse that arrives while a walk is in progress is ignored.
- R10: The result does not depend on how many wait states each read takes.
- R11: Accepting `start` clears `ok`, `ver_major` and `ver_minor` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| rd_req | output | 1 | Read request, held until answered |
| rd_addr | output | ADDR_W | Byte address of the pending read |
| rd_data | input | 8 | Returned byte, valid with `rd_valid` |
| rd_valid | input | 1 | Read response strobe |
| done | output | 1 | One-cycle end-of-walk pulse |
| ok | output | 1 | Header valid, versions extracted |
| ver_major | output | 8 | Major version byte |
| ver_minor | output | 8 | Minor version byte |

## Verification
The assertions assume the following about the read responder. It raises `rd_valid` only while `rd_req` is high. It answers each request once. It drops `rd_valid` after a single cycle. It leaves the address alone, because the address is owned by the block.

The bench's responder model follows these rules for any wait-state count. It logs each accepted address, so the read order and the early stop can be compared against the expected sequence. The bench pulses `start` only from idle, except in the scenario that checks that a `start` during a walk is ignored.

// File: rtl/romwalk_pkg.sv
package romwalk_pkg;
  localparam int NSTEP  = 9;
  localparam int STEP_W = 4;

  typedef enum logic [1:0] {
    W_IDLE,
    W_REQ,
    W_EVAL
  } walk_st_t;

  typedef enum logic [1:0] {
    K_MATCH,
    K_PTR,
    K_MINOR,
    K_MAJOR
  } step_kind_t;
endpackage

// File: rtl/romwalk_steps.sv
module romwalk_steps
  import romwalk_pkg::*;
#(
  parameter logic [7:0] SIG_LO    = 8'h55,
  parameter logic [7:0] SIG_HI    = 8'hAA,
  parameter logic [7:0] PTR_OFS   = 8'h18,
  parameter logic [7:0] MINOR_OFS = 8'h12
) (
  input  logic [STEP_W-1:0] step,
  output step_kind_t        kind,
  output logic [7:0]        exp_byte,
  output logic [7:0]        offset,
  output logic              rel
);
  localparam logic [7:0] MAJOR_OFS = MINOR_OFS + 8'd1;
  localparam logic [31:0] TAG = {8'h50, 8'h43, 8'h49, 8'h52};

  always_comb begin
    kind     = K_MATCH;
    exp_byte = 8'h00;
    offset   = 8'h00;
    rel      = 1'b0;
    case (step)
      4'd0: begin exp_byte = SIG_LO; offset = 8'h00; end
      4'd1: begin exp_byte = SIG_HI; offset = 8'h01; end
      4'd2: begin kind = K_PTR; offset = PTR_OFS; end
      4'd3, 4'd4, 4'd5, 4'd6: begin
        rel      = 1'b1;
        offset   = 8'(step - 4'd3);
        exp_byte = TAG[8*(6-int'(step)) +: 8];
      end
      4'd7: begin kind = K_MINOR; rel = 1'b1; offset = MINOR_OFS; end
      default: begin kind = K_MAJOR; rel = 1'b1; offset = MAJOR_OFS; end
    endcase
  end
endmodule

// File: rtl/romwalk_addr_gen.sv
module romwalk_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic [7:0]        ptr,
  input  logic [7:0]        offset,
  input  logic              rel,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] ZERO = '0;

  always_comb begin
    if (rel)
      addr = ZERO + ADDR_W'(ptr) + ADDR_W'(offset);
    else
      addr = ZERO + ADDR_W'(offset);
  end
endmodule

// File: rtl/romwalk_seq.sv
module romwalk_seq
  import romwalk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  input  step_kind_t        kind,
  input  logic [7:0]        exp_byte,
  output logic [STEP_W-1:0] step,
  output logic [7:0]        ptr,
  output logic              rd_req,
  output logic              done,
  output logic              ok,
  output logic [7:0]        ver_major,
  output logic [7:0]        ver_minor
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);

  walk_st_t   st;
  logic [7:0] byte_q;
  logic [7:0] minor_q;
  logic       miss;

  assign miss = (kind == K_MATCH) && (byte_q != exp_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= W_IDLE;
      step      <= '0;
      ptr       <= '0;
      byte_q    <= '0;
      minor_q   <= '0;
      rd_req    <= 1'b0;
      done      <= 1'b0;
      ok        <= 1'b0;
      ver_major <= '0;
      ver_minor <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        W_IDLE: begin
          if (start) begin
            step      <= '0;
            ok        <= 1'b0;
            ver_major <= '0;
            ver_minor <= '0;
            rd_req    <= 1'b1;
            st        <= W_REQ;
          end
        end
        W_REQ: begin
          if (rd_valid) begin
            byte_q <= rd_data;
            rd_req <= 1'b0;
            st     <= W_EVAL;
          end
        end
        default: begin
          if (kind == K_PTR)   ptr     <= byte_q;
          if (kind == K_MINOR) minor_q <= byte_q;
          if (miss) begin
            done <= 1'b1;
            st   <= W_IDLE;
          end else if (step == LAST_STEP) begin
            done      <= 1'b1;
            ok        <= 1'b1;
            ver_major <= byte_q;
            ver_minor <= minor_q;
            st        <= W_IDLE;
          end else begin
            step   <= step + 1'b1;
            rd_req <= 1'b1;
            st     <= W_REQ;
          end
        end
      endcase
    end
  end

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: versions stay zero unless the walk succeeded
  a_r8_fail_zero: assert property (@(posedge clk) disable iff (rst)
    !ok |-> (ver_major == 8'h00 && ver_minor == 8'h00));
  // R7: no read is pending when the walk reports
  a_r7_quiet_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req);
  // R11: an accepted start clears the previous result
  a_r11_clear: assert property (@(posedge clk) disable iff (rst)
    (st == W_IDLE && start) |=> (!ok && ver_major == 8'h00 && ver_minor == 8'h00));
  // R9: start while busy does not restart the step count
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (st == W_REQ && !rd_valid) |=> $stable(step));
endmodule

// File: rtl/romwalk_top.sv
module romwalk_top
  import romwalk_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter logic [7:0] SIG_LO    = 8'h55,
  parameter logic [7:0] SIG_HI    = 8'hAA,
  parameter logic [7:0] PTR_OFS   = 8'h18,
  parameter logic [7:0] MINOR_OFS = 8'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic              rd_valid,
  output logic              done,
  output logic              ok,
  output logic [7:0]        ver_major,
  output logic [7:0]        ver_minor
);
  logic [STEP_W-1:0] step;
  logic [7:0]        ptr;
  step_kind_t        kind;
  logic [7:0]        exp_byte;
  logic [7:0]        offset;
  logic              rel;

  romwalk_steps #(
    .SIG_LO(SIG_LO), .SIG_HI(SIG_HI), .PTR_OFS(PTR_OFS), .MINOR_OFS(MINOR_OFS)
  ) u_steps (
    .step(step), .kind(kind), .exp_byte(exp_byte), .offset(offset), .rel(rel)
  );

  romwalk_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .ptr(ptr), .offset(offset), .rel(rel), .addr(rd_addr)
  );

  romwalk_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .rd_valid(rd_valid), .rd_data(rd_data),
    .kind(kind), .exp_byte(exp_byte), .step(step), .ptr(ptr), .rd_req(rd_req),
    .done(done), .ok(ok), .ver_major(ver_major), .ver_minor(ver_minor)
  );

  // R2: request and address held until answered
  a_r2_hold_req: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
  // R2: the first read of a walk targets address zero
  a_r2_first_addr: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_req) && step == '0) |-> (rd_addr == '0));
endmodule

// File: tb/romwalk_top_bench.sv
`timescale 1ns/1ps
module romwalk_top_bench;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data = 8'h00;
  logic          rd_valid = 1'b0;
  logic          done, ok;
  logic [7:0]    ver_major, ver_minor;

  logic [7:0]    mem [0:511];
  logic [AW-1:0] rd_log [0:255];
  int            rd_n = 0;
  int            done_n = 0;
  int            lat = 0;
  int            wcnt = 0;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2 clk = ~clk;

  romwalk_top #(.ADDR_W(AW)) u_romwalk_top (
    .clk(clk), .rst(rst), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .ok(ok),
    .ver_major(ver_major), .ver_minor(ver_minor)
  );

  // responder: one answer per request after lat wait cycles
  always @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      wcnt     <= 0;
    end else if (rd_valid) begin
      rd_valid <= 1'b0;
    end else if (rd_req) begin
      if (wcnt >= lat) begin
        rd_valid        <= 1'b1;
        rd_data         <= mem[rd_addr[8:0]];
        rd_log[rd_n % 256] <= rd_addr;
        rd_n            <= rd_n + 1;
        wcnt            <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) if (!rst && done) done_n <= done_n + 1;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int k, input int p);
    case (k)
      0: return 0;
      1: return 1;
      2: return 24;
      3, 4, 5, 6: return p + k - 3;
      7: return p + 18;
      default: return p + 19;
    endcase
  endfunction

  task automatic build_image(input int p, input logic [7:0] mi, input logic [7:0] ma);
    for (int i = 0; i < 512; i++) mem[i] = 8'(i ^ 8'h3C);
    mem[0] = 8'h55; mem[1] = 8'hAA; mem[24] = 8'(p);
    mem[p] = 8'h50; mem[p+1] = 8'h43; mem[p+2] = 8'h49; mem[p+3] = 8'h52;
    mem[p+18] = mi; mem[p+19] = ma;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    check(done, req, 0, 1);
  endtask

  // runs one walk and checks outputs, read trace and done count
  task automatic run_walk(input string req, input int p, input int nreads,
                          input bit eok, input logic [7:0] ema, input logic [7:0] emi);
    int base_r = rd_n;
    int base_d = done_n;
    @(negedge clk);
    pulse_start();
    wait_done(req);
    check(ok == eok, req, ok, eok);
    check(ver_major == ema, req, ver_major, ema);
    check(ver_minor == emi, req, ver_minor, emi);
    repeat (6) @(negedge clk);
    check(done_n - base_d == 1, {req, " R8 done count"}, done_n - base_d, 1);
    check(rd_n - base_r == nreads, {req, " R7 read count"}, rd_n - base_r, nreads);
    for (int k = 0; k < nreads && k < rd_n - base_r; k++)
      check(int'(rd_log[(base_r + k) % 256]) == exp_addr(k, p), {req, " R2 order"},
            int'(rd_log[(base_r + k) % 256]), exp_addr(k, p));
  endtask

  task automatic t_reset();
    check(!done && !ok && !rd_req, "R1 flags", {done, ok, rd_req}, 0);
    check(ver_major == 0 && ver_minor == 0, "R1 versions", {ver_major, ver_minor}, 0);
  endtask

  task automatic t_good(input int p, input int l, input logic [7:0] mi, input logic [7:0] ma);
    lat = l;
    build_image(p, mi, ma);
    run_walk("R6 R4 R10 good", p, 9, 1'b1, ma, mi);
  endtask

  task automatic t_bad(input int k, input string req);
    lat = 1;
    build_image(64, 8'h11, 8'h22);
    if (k <= 1) mem[k] = 8'h00;
    else mem[64 + k - 3] = 8'h41;
    run_walk(req, 64, k + 1, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic t_clear();
    lat = 0;
    build_image(40, 8'h07, 8'h09);
    run_walk("R6 prep", 40, 9, 1'b1, 8'h09, 8'h07);
    @(negedge clk);
    pulse_start();
    check(!ok && ver_major == 0 && ver_minor == 0, "R11 clear on start",
          {ok, ver_major, ver_minor}, 0);
    wait_done("R11 finish");
    repeat (4) @(negedge clk);
  endtask

  task automatic t_busy();
    int base_r;
    int base_d;
    lat = 2;
    build_image(80, 8'h33, 8'h44);
    @(negedge clk);
    base_r = rd_n;
    base_d = done_n;
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    repeat (12) @(negedge clk);
    pulse_start();
    wait_done("R9 busy");
    check(ok && ver_major == 8'h44 && ver_minor == 8'h33, "R9 result",
          {ok, ver_major, ver_minor}, {1'b1, 8'h44, 8'h33});
    repeat (8) @(negedge clk);
    check(rd_n - base_r == 9, "R9 reads", rd_n - base_r, 9);
    check(done_n - base_d == 1, "R9 done count", done_n - base_d, 1);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_good(32, 0, 8'h05, 8'h02);
    t_good(100, 3, 8'hA7, 8'h1C);
    t_good(240, 5, 8'hFF, 8'h80);
    t_bad(0, "R3 byte0");
    t_bad(1, "R3 byte1");
    t_bad(3, "R5 tag0");
    t_bad(5, "R5 R7 tag2");
    t_bad(6, "R5 tag3");
    t_clear();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule